// File: doc/BRIEF.md
# DRAM Command Spacing Gate

This block sits beside a memory controller's command issue stage. Each cycle the controller proposes one DRAM command: a kind, a bank and a bank group. The block answers with `cmd_ready`, which tells whether that command may go out in this cycle without breaking any minimum spacing rule that earlier issued commands have set up. When the controller actually sends a command it pulses `cmd_issue`, and the block loads the spacing that command imposes on later traffic.

Spacing state is held in saturating down-counters. There is one pair per bank (activate side and precharge side), one pair per bank group (read side and write side), and a few global ones: any-group read, any-group write, power-down entry, precharge-all and refresh. An issued command raises each counter it affects to the larger of the counter's current remaining wait and the new wait. All timings are parameters in clock cycles. Burst data time is the burst length divided by the data rate. A single-rate device instead uses one less than the burst length for writes. A command sent while `cmd_ready` is low sets a sticky `timing_violation` flag.

Top module: `dram_cmd_timing_gate`

## Requirements
- R1: After reset `timing_violation` is 0 and every valid known command has `cmd_ready` high in the first cycle.
- R2: `cmd_ready` is 0 while `cmd_valid` is 0, and for any `cmd_type` code outside the encoding ACT=0, RD=1, RDA=2, WR=3, WRA=4, PRE=5, PREA=6, REF=7, PDN=8.
- R3: Two reads (RD/RDA), or two writes (WR/WRA), are spaced by max(tCCD_L, burst) in the same bank group and by max(tCCD_S, burst) across groups (defaults: 6 and 4 cycles).
- R4: A write followed by a read waits tWL + write burst + tWTR_L in the same group, or with tWTR_S across groups (defaults 15 / 11).
- R5: A read followed by a write waits tRL + read burst − tWL + 2 in any group (default 8).
- R6: A write followed by PRE of the same bank waits tWL + write burst + tWR (default 17); PRE of another bank is not delayed.
- R7: WRA followed by ACT of the same bank or by REF waits tWL + write burst + tWR + tRP (default 23); power-down entry waits tWL + write burst + tWR after WR (17) and one more cycle after WRA (18).
- R8: RDA followed by ACT of the same bank or by PREA waits tRTP + tRP (default 10); RD followed by PRE of the same bank waits tRTP (default 4).
- R9: RD or RDA followed by power-down entry waits tRL + read burst + 1 (default 12).
- R10: After REF no command of any kind is ready for tRFC cycles (default 20).
- R11: `timing_violation` rises after a cycle with `cmd_issue` high and `cmd_ready` low, and stays high until reset; issues made while ready leave it low.
- R12: A later command that imposes a shorter wait on a counter never shortens the wait already pending there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | A command is proposed this cycle |
| cmd_type | input | 4 | Command kind, encoding in R2 |
| cmd_bank | input | $clog2(NUM_BANKS) | Target bank |
| cmd_group | input | $clog2(NUM_GROUPS) | Target bank group |
| cmd_issue | input | 1 | The proposed command is sent this cycle |
| cmd_ready | output | 1 | The proposed command meets all spacing rules |
| timing_violation | output | 1 | Sticky: a command was sent while not ready |

## Verification
The assertions assume that `cmd_issue` only comes with `cmd_valid` and a known command code. They also assume that bank and group indices stay within the configured counts, and that the refresh time is more than one cycle. The bench drives every command through tasks that always set `cmd_valid` along with `cmd_issue`. It uses only in-range bank and group values. It breaks a spacing rule on purpose only in the violation and max-hold scenarios, and it resets after each one.

// File: rtl/dct_pkg.sv
package dct_pkg;

    typedef enum logic [3:0] {
        CMD_ACT  = 4'd0,
        CMD_RD   = 4'd1,
        CMD_RDA  = 4'd2,
        CMD_WR   = 4'd3,
        CMD_WRA  = 4'd4,
        CMD_PRE  = 4'd5,
        CMD_PREA = 4'd6,
        CMD_REF  = 4'd7,
        CMD_PDN  = 4'd8
    } dct_cmd_e;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dct_gap_counter.sv
module dct_gap_counter #(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_en,
    input  logic [CW-1:0] load_gap,
    output logic          idle
);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } cnt_state_t;

    cnt_state_t state_d, state_q;
    logic [CW-1:0] dec_val;
    logic [CW-1:0] tgt_val;

    always_comb begin
        dec_val = (state_q.cnt == '0) ? '0 : state_q.cnt - CW'(1);
        tgt_val = (load_gap == '0) ? '0 : load_gap - CW'(1);
        state_d = state_q;
        state_d.cnt = (load_en && (tgt_val > dec_val)) ? tgt_val : dec_val;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign idle = (state_q.cnt == '0);

    // R12: without a load the wait only counts down by one
    a_r12_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && state_q.cnt != '0) |=> (state_q.cnt == $past(state_q.cnt) - CW'(1)));

    // R12: after a load the pending wait is at least the new one
    a_r12_holds_max: assert property (@(posedge clk) disable iff (!rst_n)
        (load_en && load_gap != '0) |=> (state_q.cnt >= $past(load_gap) - CW'(1)));

endmodule

// File: rtl/dct_ready_dec.sv
module dct_ready_dec
    import dct_pkg::*;
#(
    parameter int NUM_BANKS  = 4,
    parameter int NUM_GROUPS = 2,
    localparam int BW = $clog2(NUM_BANKS),
    localparam int GW = $clog2(NUM_GROUPS)
) (
    input  logic                  cmd_valid,
    input  logic [3:0]            cmd_type,
    input  logic [BW-1:0]         cmd_bank,
    input  logic [GW-1:0]         cmd_group,
    input  logic [NUM_BANKS-1:0]  act_idle,
    input  logic [NUM_BANKS-1:0]  pre_idle,
    input  logic [NUM_GROUPS-1:0] rdg_idle,
    input  logic [NUM_GROUPS-1:0] wrg_idle,
    input  logic                  rd_any_idle,
    input  logic                  wr_any_idle,
    input  logic                  pdn_idle,
    input  logic                  pall_idle,
    input  logic                  glob_idle,
    output logic                  ready
);

    logic kind_ok;

    always_comb begin
        case (dct_cmd_e'(cmd_type))
            CMD_ACT:         kind_ok = act_idle[cmd_bank];
            CMD_RD, CMD_RDA: kind_ok = rdg_idle[cmd_group] && rd_any_idle;
            CMD_WR, CMD_WRA: kind_ok = wrg_idle[cmd_group] && wr_any_idle;
            CMD_PRE:         kind_ok = pre_idle[cmd_bank];
            CMD_PREA:        kind_ok = (&pre_idle) && pall_idle;
            CMD_REF:         kind_ok = &act_idle;
            CMD_PDN:         kind_ok = pdn_idle;
            default:         kind_ok = 1'b0;
        endcase
        ready = cmd_valid && glob_idle && kind_ok;
    end

endmodule

// File: rtl/dram_cmd_timing_gate.sv
module dram_cmd_timing_gate
    import dct_pkg::*;
#(
    parameter int NUM_BANKS  = 4,
    parameter int NUM_GROUPS = 2,
    parameter int BURST_LEN  = 8,
    parameter int DATA_RATE  = 2,
    parameter int T_CCD_L    = 6,
    parameter int T_CCD_S    = 4,
    parameter int T_WL       = 5,
    parameter int T_RL       = 7,
    parameter int T_WTR_L    = 6,
    parameter int T_WTR_S    = 2,
    parameter int T_WR       = 8,
    parameter int T_RTP      = 4,
    parameter int T_RP       = 6,
    parameter int T_RFC      = 20,
    localparam int BW = $clog2(NUM_BANKS),
    localparam int GW = $clog2(NUM_GROUPS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [3:0]    cmd_type,
    input  logic [BW-1:0] cmd_bank,
    input  logic [GW-1:0] cmd_group,
    input  logic          cmd_issue,
    output logic          cmd_ready,
    output logic          timing_violation
);

    localparam int RB        = BURST_LEN / DATA_RATE;
    localparam int WB        = (DATA_RATE == 1) ? BURST_LEN - 1 : BURST_LEN / DATA_RATE;
    localparam int G_RR_L    = imax(T_CCD_L, RB);
    localparam int G_RR_S    = imax(T_CCD_S, RB);
    localparam int G_WW_L    = imax(T_CCD_L, WB);
    localparam int G_WW_S    = imax(T_CCD_S, WB);
    localparam int G_WR_RD_L = T_WL + WB + T_WTR_L;
    localparam int G_WR_RD_S = T_WL + WB + T_WTR_S;
    localparam int G_RD_WR   = T_RL + RB - T_WL + 2;
    localparam int G_WR_PRE  = T_WL + WB + T_WR;
    localparam int G_WRA_ACT = G_WR_PRE + T_RP;
    localparam int G_WRA_PDN = G_WR_PRE + 1;
    localparam int G_RDA_ACT = T_RTP + T_RP;
    localparam int G_RD_PRE  = T_RTP;
    localparam int G_RD_PDN  = T_RL + RB + 1;
    localparam int G_REF     = T_RFC;
    localparam int G_MAX     = imax(imax(imax(G_WRA_ACT, G_REF), imax(G_WR_RD_L, G_RD_PDN)),
                                    imax(imax(G_RR_L, G_WW_L), imax(G_RD_WR, G_RDA_ACT)));
    localparam int CW        = $clog2(G_MAX + 1);

    typedef struct packed {
        logic viol;
    } top_state_t;

    top_state_t state_d, state_q;
    dct_cmd_e   kind;

    logic [NUM_BANKS-1:0]  act_ld, pre_ld, act_idle, pre_idle;
    logic [NUM_GROUPS-1:0] rdg_ld, wrg_ld, rdg_idle, wrg_idle;
    logic rda_ld, wra_ld, pdn_ld, pall_ld, glob_ld;
    logic rda_idle, wra_idle, pdn_idle, pall_idle, glob_idle;
    logic [CW-1:0] act_gap, pre_gap, rdg_gap, wrg_gap;
    logic [CW-1:0] rda_gap, wra_gap, pdn_gap, pall_gap, glob_gap;

    assign kind = dct_cmd_e'(cmd_type);

    always_comb begin
        act_ld = '0;  pre_ld = '0;  rdg_ld = '0;  wrg_ld = '0;
        rda_ld = 1'b0; wra_ld = 1'b0; pdn_ld = 1'b0; pall_ld = 1'b0; glob_ld = 1'b0;
        act_gap = '0; pre_gap = '0; rdg_gap = '0; wrg_gap = '0;
        rda_gap = '0; wra_gap = '0; pdn_gap = '0; pall_gap = '0; glob_gap = '0;
        if (cmd_issue) begin
            case (kind)
                CMD_RD, CMD_RDA: begin
                    rdg_ld[cmd_group] = 1'b1; rdg_gap = CW'(G_RR_L);
                    rda_ld = 1'b1;            rda_gap = CW'(G_RR_S);
                    wra_ld = 1'b1;            wra_gap = CW'(G_RD_WR);
                    pre_ld[cmd_bank] = 1'b1;  pre_gap = CW'(G_RD_PRE);
                    pdn_ld = 1'b1;            pdn_gap = CW'(G_RD_PDN);
                    if (kind == CMD_RDA) begin
                        act_ld[cmd_bank] = 1'b1; act_gap  = CW'(G_RDA_ACT);
                        pall_ld = 1'b1;          pall_gap = CW'(G_RDA_ACT);
                    end
                end
                CMD_WR, CMD_WRA: begin
                    wrg_ld[cmd_group] = 1'b1; wrg_gap = CW'(G_WW_L);
                    wra_ld = 1'b1;            wra_gap = CW'(G_WW_S);
                    rdg_ld[cmd_group] = 1'b1; rdg_gap = CW'(G_WR_RD_L);
                    rda_ld = 1'b1;            rda_gap = CW'(G_WR_RD_S);
                    pre_ld[cmd_bank] = 1'b1;  pre_gap = CW'(G_WR_PRE);
                    pdn_ld = 1'b1;
                    pdn_gap = (kind == CMD_WRA) ? CW'(G_WRA_PDN) : CW'(G_WR_PRE);
                    if (kind == CMD_WRA) begin
                        act_ld[cmd_bank] = 1'b1; act_gap = CW'(G_WRA_ACT);
                    end
                end
                CMD_REF: begin
                    glob_ld = 1'b1; glob_gap = CW'(G_REF);
                end
                default: ;
            endcase
        end
    end

    generate
        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
            dct_gap_counter #(.CW(CW)) u_act (.clk(clk), .rst_n(rst_n), .load_en(act_ld[b]),
                .load_gap(act_gap), .idle(act_idle[b]));
            dct_gap_counter #(.CW(CW)) u_pre (.clk(clk), .rst_n(rst_n), .load_en(pre_ld[b]),
                .load_gap(pre_gap), .idle(pre_idle[b]));
        end
        for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_group
            dct_gap_counter #(.CW(CW)) u_rd (.clk(clk), .rst_n(rst_n), .load_en(rdg_ld[g]),
                .load_gap(rdg_gap), .idle(rdg_idle[g]));
            dct_gap_counter #(.CW(CW)) u_wr (.clk(clk), .rst_n(rst_n), .load_en(wrg_ld[g]),
                .load_gap(wrg_gap), .idle(wrg_idle[g]));
        end
    endgenerate

    dct_gap_counter #(.CW(CW)) u_rd_any (.clk(clk), .rst_n(rst_n), .load_en(rda_ld),
        .load_gap(rda_gap), .idle(rda_idle));
    dct_gap_counter #(.CW(CW)) u_wr_any (.clk(clk), .rst_n(rst_n), .load_en(wra_ld),
        .load_gap(wra_gap), .idle(wra_idle));
    dct_gap_counter #(.CW(CW)) u_pdn (.clk(clk), .rst_n(rst_n), .load_en(pdn_ld),
        .load_gap(pdn_gap), .idle(pdn_idle));
    dct_gap_counter #(.CW(CW)) u_pall (.clk(clk), .rst_n(rst_n), .load_en(pall_ld),
        .load_gap(pall_gap), .idle(pall_idle));
    dct_gap_counter #(.CW(CW)) u_glob (.clk(clk), .rst_n(rst_n), .load_en(glob_ld),
        .load_gap(glob_gap), .idle(glob_idle));

    dct_ready_dec #(.NUM_BANKS(NUM_BANKS), .NUM_GROUPS(NUM_GROUPS)) u_dec (
        .cmd_valid(cmd_valid), .cmd_type(cmd_type), .cmd_bank(cmd_bank), .cmd_group(cmd_group),
        .act_idle(act_idle), .pre_idle(pre_idle), .rdg_idle(rdg_idle), .wrg_idle(wrg_idle),
        .rd_any_idle(rda_idle), .wr_any_idle(wra_idle), .pdn_idle(pdn_idle),
        .pall_idle(pall_idle), .glob_idle(glob_idle), .ready(cmd_ready));

    always_comb begin
        state_d = state_q;
        state_d.viol = state_q.viol | (cmd_issue & ~cmd_ready);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign timing_violation = state_q.viol;

    // R11: once raised the flag stays up
    a_r11_violation_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        timing_violation |=> timing_violation);

    // R11: an early issue is flagged in the next cycle
    a_r11_early_issue_flagged: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_issue && !cmd_ready) |=> timing_violation);

    // R2: nothing is ready without a proposal
    a_r2_ready_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |-> !cmd_ready);

    // R10: the cycle after a refresh is blocked for every command
    a_r10_refresh_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        ((G_REF > 1) && cmd_issue && kind == CMD_REF) |=> !cmd_ready);

endmodule

// File: tb/sim_dram_cmd_timing_gate.sv
module sim_dram_cmd_timing_gate;
    import dct_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cmd_valid;
    logic [3:0] cmd_type;
    logic [1:0] cmd_bank;
    logic [0:0] cmd_group;
    logic       cmd_issue;
    logic       cmd_ready;
    logic       timing_violation;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dram_cmd_timing_gate u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_type(cmd_type),
        .cmd_bank(cmd_bank), .cmd_group(cmd_group), .cmd_issue(cmd_issue),
        .cmd_ready(cmd_ready), .timing_violation(timing_violation));

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; cmd_valid = 1'b0; cmd_issue = 1'b0;
        cmd_type = 4'(CMD_ACT); cmd_bank = '0; cmd_group = '0;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic send(input dct_cmd_e k, input int b, input int g);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_issue = 1'b1;
        cmd_type = 4'(k); cmd_bank = 2'(b); cmd_group = 1'(g);
        @(posedge clk);
    endtask

    // cycles from the last send until the proposed command is ready
    task automatic measure(input dct_cmd_e k, input int b, input int g, output int cyc);
        cyc = 60;
        for (int i = 1; i <= 60; i++) begin
            @(negedge clk);
            cmd_valid = 1'b1; cmd_issue = 1'b0;
            cmd_type = 4'(k); cmd_bank = 2'(b); cmd_group = 1'(g);
            #1;
            if (cmd_ready) begin
                cyc = i;
                break;
            end
        end
    endtask

    task automatic gap_case(input string req, input dct_cmd_e k1, input int b1, input int g1,
                            input dct_cmd_e k2, input int b2, input int g2, input int exp);
        int c;
        do_reset();
        send(k1, b1, g1);
        measure(k2, b2, g2, c);
        check(req, c, exp);
    endtask

    task automatic t_r1_reset();
        do_reset();
        #1;
        check("R1 violation after reset", int'(timing_violation), 0);
        cmd_valid = 1'b1; cmd_type = 4'(CMD_ACT); cmd_bank = 2'd2;
        #1;
        check("R1 ACT ready after reset", int'(cmd_ready), 1);
        cmd_type = 4'(CMD_REF);
        #1;
        check("R1 REF ready after reset", int'(cmd_ready), 1);
    endtask

    task automatic t_r2_valid();
        do_reset();
        cmd_valid = 1'b0; cmd_type = 4'(CMD_RD);
        #1;
        check("R2 not ready without valid", int'(cmd_ready), 0);
        cmd_valid = 1'b1; cmd_type = 4'hF;
        #1;
        check("R2 unknown code not ready", int'(cmd_ready), 0);
    endtask

    task automatic t_r3_ccd();
        gap_case("R3 RD-RD same group", CMD_RD, 0, 0, CMD_RD, 1, 0, 6);
        gap_case("R3 RD-RDA other group", CMD_RD, 0, 0, CMD_RDA, 1, 1, 4);
        gap_case("R3 WR-WR same group", CMD_WR, 0, 1, CMD_WRA, 2, 1, 6);
        gap_case("R3 WR-WR other group", CMD_WR, 0, 0, CMD_WR, 3, 1, 4);
    endtask

    task automatic t_r4_wtr();
        gap_case("R4 WR-RD same group", CMD_WR, 0, 0, CMD_RD, 1, 0, 15);
        gap_case("R4 WR-RD other group", CMD_WRA, 0, 0, CMD_RD, 1, 1, 11);
    endtask

    task automatic t_r5_rtw();
        gap_case("R5 RD-WR same group", CMD_RD, 0, 0, CMD_WR, 0, 0, 8);
        gap_case("R5 RD-WR other group", CMD_RDA, 0, 0, CMD_WR, 1, 1, 8);
    endtask

    task automatic t_r6_wr_pre();
        gap_case("R6 WR-PRE same bank", CMD_WR, 0, 0, CMD_PRE, 0, 0, 17);
        gap_case("R6 WR-PRE other bank", CMD_WR, 0, 0, CMD_PRE, 1, 0, 1);
    endtask

    task automatic t_r7_wra();
        gap_case("R7 WRA-ACT same bank", CMD_WRA, 1, 0, CMD_ACT, 1, 0, 23);
        gap_case("R7 WRA-REF", CMD_WRA, 1, 0, CMD_REF, 0, 0, 23);
        gap_case("R7 WRA-PDN", CMD_WRA, 1, 0, CMD_PDN, 0, 0, 18);
        gap_case("R7 WR-PDN", CMD_WR, 1, 0, CMD_PDN, 0, 0, 17);
    endtask

    task automatic t_r8_rda();
        gap_case("R8 RDA-ACT same bank", CMD_RDA, 2, 0, CMD_ACT, 2, 0, 10);
        gap_case("R8 RDA-PREA", CMD_RDA, 2, 0, CMD_PREA, 0, 0, 10);
        gap_case("R8 RD-PRE same bank", CMD_RD, 2, 0, CMD_PRE, 2, 0, 4);
    endtask

    task automatic t_r9_rd_pdn();
        gap_case("R9 RD-PDN", CMD_RD, 0, 0, CMD_PDN, 0, 0, 12);
        gap_case("R9 RDA-PDN", CMD_RDA, 3, 1, CMD_PDN, 0, 0, 12);
    endtask

    task automatic t_r10_ref();
        gap_case("R10 REF-ACT", CMD_REF, 0, 0, CMD_ACT, 3, 0, 20);
        gap_case("R10 REF-RD", CMD_REF, 0, 0, CMD_RD, 0, 1, 20);
    endtask

    task automatic t_r11_violation();
        int c;
        do_reset();
        send(CMD_RD, 0, 0);
        measure(CMD_RD, 1, 0, c);
        send(CMD_RD, 1, 0);
        @(negedge clk);
        cmd_issue = 1'b0;
        #1;
        check("R11 legal issues leave flag low", int'(timing_violation), 0);
        send(CMD_RD, 0, 0);
        @(negedge clk);
        cmd_issue = 1'b0; cmd_valid = 1'b0;
        #1;
        check("R11 early issue flagged", int'(timing_violation), 1);
        repeat (30) @(negedge clk);
        #1;
        check("R11 flag sticky", int'(timing_violation), 1);
    endtask

    task automatic t_r12_max_hold();
        int c;
        do_reset();
        send(CMD_WR, 0, 0);
        send(CMD_RD, 0, 0);
        measure(CMD_PRE, 0, 0, c);
        check("R12 shorter load keeps longer wait", c, 16);
    endtask

    initial begin
        rst_n = 1'b0; cmd_valid = 1'b0; cmd_issue = 1'b0;
        cmd_type = '0; cmd_bank = '0; cmd_group = '0;
        t_r1_reset();
        t_r2_valid();
        t_r3_ccd();
        t_r4_wtr();
        t_r5_rtw();
        t_r6_wr_pre();
        t_r7_wra();
        t_r8_rda();
        t_r9_rd_pdn();
        t_r10_ref();
        t_r11_violation();
        t_r12_max_hold();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule